// File: doc/BRIEF.md
# Memory Fill and Readback Checker

This block is a self-running AXI4 master that tests a fixed window of memory. A single-cycle start pulse launches a write phase that fills the window with an incrementing count, using a fixed number of equal INCR bursts. Once every write response has come back, a read phase fetches the same window with matching read bursts. Each returned word is compared with the value that was written.

The results are reported on a handful of status pins: busy, done, pass, fail and the byte address of the first failure. The block is meant to sit on a spare port of a memory interconnect as a built-in memory test. It needs no software setup. The window base, the burst count and the burst length are elaboration parameters. The defaults are base 0xA1000000, 10 bursts and 16 beats of 32-bit words, which covers 640 bytes.

Top module: `memfill_verify`

## Requirements
- R1: After reset, every valid output of the block is low, and busy, done, pass and fail are low, with fail_addr at zero.
- R2: A start pulse is accepted only while the block is idle or done. It clears done, pass and fail and raises busy in the following cycle. A start pulse while busy has no effect on the run in progress.
- R3: The write phase issues exactly NUM_BURSTS write addresses, the k-th being BASE_ADDR + k*64. Each has length field 15 (16 beats), size code 2 (4-byte beats), burst code 1 (INCR), protection 0 and all write strobes set.
- R4: Write data for word index i (counted from the base, i = 0..159) is the value i. The last-beat flag is high on beat 15 of every burst and on no other beat.
- R5: No read address is issued before all NUM_BURSTS write responses have been accepted. The read addresses repeat the write addresses in the same order, with length field 15, size code 2, burst code 1 and protection 0.
- R6: Once a valid is raised on the write-address, write-data or read-address channel, it stays high with an unchanged payload until the matching ready is seen.
- R7: A read word that differs from its index, or whose last-beat flag is wrong, sets fail. Fail then stays set until the next accepted start. fail_addr holds the byte address (BASE_ADDR + 4*i) of the first failing word.
- R8: A write response other than OKAY (code 0) counts as a failure at the start address of that burst. A read response other than OKAY counts as a failure at that beat's address. Only the first failure of a run sets fail_addr, and the run still completes.
- R9: done rises in the cycle after the last read beat is accepted and holds until the next accepted start. pass is high exactly when done is high and fail is low.
- R10: The write-response ready is high only during the write phase. The read-data ready is high only during the read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished |
| pass | output | 1 | Finished with no failure |
| fail | output | 1 | Sticky failure flag |
| fail_addr | output | 32 | Byte address of first failure |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Write burst start address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awprot | output | 3 | Write protection, zero |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_wlast | output | 1 | Last beat of write burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | 32 | Read burst start address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arprot | output | 3 | Read protection, zero |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last beat of read burst |

## Verification
A counter slipping in the write engine shows up at once as a wrong address on the write-address channel or a misplaced last-beat flag. It also shows up later as a spurious fail, because the read-back words no longer match their indices. A broken phase handoff appears as a read address issued while write responses are still outstanding, or as done never rising. A comparator fault shows as a missing or wrong fail_addr as soon as done rises after a deliberately corrupted word or an error response. The slave model stalls its ready signals at random, so a held payload that changes before acceptance is caught in the same cycle.

// File: rtl/memfill_pkg.sv
package memfill_pkg;

    localparam int ADDR_W         = 32;
    localparam int DATA_W         = 32;
    localparam int BYTES_PER_WORD = DATA_W / 8;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [2:0] SIZE_CODE  = 3'($clog2(BYTES_PER_WORD));

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WRITE,
        PH_READ,
        PH_DONE
    } phase_e;

    // A failure event raised by one engine for the verdict logic
    typedef struct packed {
        logic  hit;
        addr_t addr;
    } fault_t;

    // One accepted read beat together with what it should have been
    typedef struct packed {
        logic       fire;
        addr_t      addr;
        word_t      data;
        word_t      golden;
        logic [1:0] resp;
        logic       last_seen;
        logic       last_golden;
    } rd_beat_t;

    function automatic word_t pattern_word(input logic [31:0] idx);
        return word_t'(idx);
    endfunction

    function automatic addr_t word_addr(input addr_t base, input logic [31:0] idx);
        return base + addr_t'(idx) * addr_t'(BYTES_PER_WORD);
    endfunction

    function automatic addr_t burst_addr(input addr_t base, input logic [31:0] burst,
                                         input int beats);
        return base + addr_t'(burst) * addr_t'(beats * BYTES_PER_WORD);
    endfunction

endpackage

// File: rtl/mf_wr_engine.sv
module mf_wr_engine
    import memfill_pkg::*;
#(
    parameter addr_t BASE_ADDR   = 32'hA100_0000,
    parameter int    NUM_BURSTS  = 10,
    parameter int    BURST_BEATS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    output logic       awvalid,
    input  logic       awready,
    output addr_t      awaddr,
    output logic       wvalid,
    input  logic       wready,
    output word_t      wdata,
    output logic       wlast,
    input  logic       bvalid,
    output logic       bready,
    input  logic [1:0] bresp,
    output logic       phase_done,
    output fault_t     fault
);

    localparam int TOTAL = NUM_BURSTS * BURST_BEATS;
    localparam int BCW   = $clog2(NUM_BURSTS + 1);
    localparam int IW    = $clog2(TOTAL + 1);
    localparam int BTW   = $clog2(BURST_BEATS);

    logic           active;
    logic [BCW-1:0] aw_cnt;
    logic [BCW-1:0] b_cnt;
    logic [IW-1:0]  w_idx;
    logic [BTW-1:0] w_beat;
    logic           aw_fire, w_fire, b_fire;

    assign awvalid = active && (aw_cnt != BCW'(NUM_BURSTS));
    assign awaddr  = burst_addr(BASE_ADDR, 32'(aw_cnt), BURST_BEATS);
    assign wvalid  = active && (w_idx != IW'(TOTAL));
    assign wdata   = pattern_word(32'(w_idx));
    assign wlast   = (w_beat == BTW'(BURST_BEATS - 1));
    assign bready  = active && (b_cnt != BCW'(NUM_BURSTS));

    assign aw_fire = awvalid && awready;
    assign w_fire  = wvalid && wready;
    assign b_fire  = bvalid && bready;

    assign phase_done = b_fire && (b_cnt == BCW'(NUM_BURSTS - 1));
    assign fault.hit  = b_fire && (bresp != RESP_OKAY);
    assign fault.addr = burst_addr(BASE_ADDR, 32'(b_cnt), BURST_BEATS);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            aw_cnt <= '0;
            b_cnt  <= '0;
            w_idx  <= '0;
            w_beat <= '0;
        end else if (go) begin
            active <= 1'b1;
            aw_cnt <= '0;
            b_cnt  <= '0;
            w_idx  <= '0;
            w_beat <= '0;
        end else if (active) begin
            if (aw_fire) aw_cnt <= aw_cnt + 1'b1;
            if (w_fire) begin
                w_idx  <= w_idx + 1'b1;
                w_beat <= wlast ? '0 : w_beat + 1'b1;
            end
            if (b_fire)     b_cnt  <= b_cnt + 1'b1;
            if (phase_done) active <= 1'b0;
        end
    end

    // R6: address and data channels hold their payload while stalled
    assert_aw_hold_R6: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(awaddr));
    assert_w_hold_R6: assert property (@(posedge clk) disable iff (rst)
        wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

endmodule

// File: rtl/mf_rd_engine.sv
module mf_rd_engine
    import memfill_pkg::*;
#(
    parameter addr_t BASE_ADDR   = 32'hA100_0000,
    parameter int    NUM_BURSTS  = 10,
    parameter int    BURST_BEATS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    output logic       arvalid,
    input  logic       arready,
    output addr_t      araddr,
    input  logic       rvalid,
    output logic       rready,
    input  word_t      rdata,
    input  logic [1:0] rresp,
    input  logic       rlast,
    output rd_beat_t   beat,
    output logic       phase_done
);

    localparam int TOTAL = NUM_BURSTS * BURST_BEATS;
    localparam int BCW   = $clog2(NUM_BURSTS + 1);
    localparam int IW    = $clog2(TOTAL + 1);
    localparam int BTW   = $clog2(BURST_BEATS);

    logic           active;
    logic [BCW-1:0] ar_cnt;
    logic [IW-1:0]  r_idx;
    logic [BTW-1:0] r_beat;
    logic           ar_fire;

    assign arvalid = active && (ar_cnt != BCW'(NUM_BURSTS));
    assign araddr  = burst_addr(BASE_ADDR, 32'(ar_cnt), BURST_BEATS);
    assign rready  = active;
    assign ar_fire = arvalid && arready;

    assign beat.fire        = rvalid && rready;
    assign beat.addr        = word_addr(BASE_ADDR, 32'(r_idx));
    assign beat.data        = rdata;
    assign beat.golden      = pattern_word(32'(r_idx));
    assign beat.resp        = rresp;
    assign beat.last_seen   = rlast;
    assign beat.last_golden = (r_beat == BTW'(BURST_BEATS - 1));

    assign phase_done = beat.fire && (r_idx == IW'(TOTAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ar_cnt <= '0;
            r_idx  <= '0;
            r_beat <= '0;
        end else if (go) begin
            active <= 1'b1;
            ar_cnt <= '0;
            r_idx  <= '0;
            r_beat <= '0;
        end else if (active) begin
            if (ar_fire) ar_cnt <= ar_cnt + 1'b1;
            if (beat.fire) begin
                r_idx  <= r_idx + 1'b1;
                r_beat <= beat.last_golden ? '0 : r_beat + 1'b1;
            end
            if (phase_done) active <= 1'b0;
        end
    end

    // R6: read address held until accepted
    assert_ar_hold_R6: assert property (@(posedge clk) disable iff (rst)
        arvalid && !arready |=> arvalid && $stable(araddr));

endmodule

// File: rtl/mf_verdict.sv
module mf_verdict
    import memfill_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  fault_t   wr_fault,
    input  rd_beat_t beat,
    output logic     fail,
    output addr_t    fail_addr
);

    logic bad_beat;

    assign bad_beat = beat.fire &&
                      ((beat.data != beat.golden) ||
                       (beat.resp != RESP_OKAY)   ||
                       (beat.last_seen != beat.last_golden));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
        end else if (!fail) begin
            if (wr_fault.hit) begin
                fail      <= 1'b1;
                fail_addr <= wr_fault.addr;
            end else if (bad_beat) begin
                fail      <= 1'b1;
                fail_addr <= beat.addr;
            end
        end
    end

    // R7: the first failure is kept until a new run clears it
    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        fail && !clear |=> fail && $stable(fail_addr));

endmodule

// File: rtl/memfill_verify.sv
module memfill_verify
    import memfill_pkg::*;
#(
    parameter addr_t BASE_ADDR   = 32'hA100_0000,
    parameter int    NUM_BURSTS  = 10,
    parameter int    BURST_BEATS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic        pass,
    output logic        fail,
    output logic [31:0] fail_addr,
    output logic        m_awvalid,
    input  logic        m_awready,
    output logic [31:0] m_awaddr,
    output logic [7:0]  m_awlen,
    output logic [2:0]  m_awsize,
    output logic [1:0]  m_awburst,
    output logic [2:0]  m_awprot,
    output logic        m_wvalid,
    input  logic        m_wready,
    output logic [31:0] m_wdata,
    output logic [3:0]  m_wstrb,
    output logic        m_wlast,
    input  logic        m_bvalid,
    output logic        m_bready,
    input  logic [1:0]  m_bresp,
    output logic        m_arvalid,
    input  logic        m_arready,
    output logic [31:0] m_araddr,
    output logic [7:0]  m_arlen,
    output logic [2:0]  m_arsize,
    output logic [1:0]  m_arburst,
    output logic [2:0]  m_arprot,
    input  logic        m_rvalid,
    output logic        m_rready,
    input  logic [31:0] m_rdata,
    input  logic [1:0]  m_rresp,
    input  logic        m_rlast
);

    localparam int BCW = $clog2(NUM_BURSTS + 1);

    phase_e   phase;
    logic     start_ok;
    logic     wr_done, rd_done;
    fault_t   wr_fault;
    rd_beat_t rd_beat;

    assign start_ok = start && ((phase == PH_IDLE) || (phase == PH_DONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE: if (start_ok) phase <= PH_WRITE;
                PH_WRITE:         if (wr_done)  phase <= PH_READ;
                PH_READ:          if (rd_done)  phase <= PH_DONE;
                default:                        phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase == PH_WRITE) || (phase == PH_READ);
    assign done = (phase == PH_DONE);
    assign pass = done && !fail;

    assign m_awlen   = 8'(BURST_BEATS - 1);
    assign m_awsize  = SIZE_CODE;
    assign m_awburst = BURST_INCR;
    assign m_awprot  = 3'b000;
    assign m_wstrb   = '1;
    assign m_arlen   = 8'(BURST_BEATS - 1);
    assign m_arsize  = SIZE_CODE;
    assign m_arburst = BURST_INCR;
    assign m_arprot  = 3'b000;

    mf_wr_engine #(
        .BASE_ADDR  (BASE_ADDR),
        .NUM_BURSTS (NUM_BURSTS),
        .BURST_BEATS(BURST_BEATS)
    ) u_wr (
        .clk       (clk),
        .rst       (rst),
        .go        (start_ok),
        .awvalid   (m_awvalid),
        .awready   (m_awready),
        .awaddr    (m_awaddr),
        .wvalid    (m_wvalid),
        .wready    (m_wready),
        .wdata     (m_wdata),
        .wlast     (m_wlast),
        .bvalid    (m_bvalid),
        .bready    (m_bready),
        .bresp     (m_bresp),
        .phase_done(wr_done),
        .fault     (wr_fault)
    );

    mf_rd_engine #(
        .BASE_ADDR  (BASE_ADDR),
        .NUM_BURSTS (NUM_BURSTS),
        .BURST_BEATS(BURST_BEATS)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .go        (wr_done),
        .arvalid   (m_arvalid),
        .arready   (m_arready),
        .araddr    (m_araddr),
        .rvalid    (m_rvalid),
        .rready    (m_rready),
        .rdata     (m_rdata),
        .rresp     (m_rresp),
        .rlast     (m_rlast),
        .beat      (rd_beat),
        .phase_done(rd_done)
    );

    mf_verdict u_verdict (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_ok),
        .wr_fault (wr_fault),
        .beat     (rd_beat),
        .fail     (fail),
        .fail_addr(fail_addr)
    );

    // Checker-only count of accepted write responses in the current run
    logic [BCW-1:0] b_seen;
    always_ff @(posedge clk) begin
        if (rst || start_ok)                b_seen <= '0;
        else if (m_bvalid && m_bready)      b_seen <= b_seen + 1'b1;
    end

    // R5: reads wait for every write response
    assert_ar_after_writes_R5: assert property (@(posedge clk) disable iff (rst)
        m_arvalid |-> (b_seen == BCW'(NUM_BURSTS)));
    // R9: done rises only right after an accepted read beat
    assert_done_after_beat_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(m_rvalid && m_rready));
    // R10: response readies confined to their phases
    assert_ready_phase_R10: assert property (@(posedge clk) disable iff (rst)
        !(m_bready && m_rready));

endmodule

// File: tb/tb_memfill_verify.sv
`timescale 1ns/1ps
module tb_memfill_verify;

    localparam logic [31:0] BASE  = 32'hA100_0000;
    localparam int          NB    = 10;
    localparam int          BL    = 16;
    localparam int          TOTAL = NB * BL;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        model_clr = 1'b0;
    logic        busy, done, pass, fail;
    logic [31:0] fail_addr;
    logic        m_awvalid, m_wvalid, m_wlast, m_bready, m_arvalid, m_rready;
    logic [31:0] m_awaddr, m_wdata, m_araddr;
    logic [7:0]  m_awlen, m_arlen;
    logic [2:0]  m_awsize, m_arsize, m_awprot, m_arprot;
    logic [1:0]  m_awburst, m_arburst;
    logic [3:0]  m_wstrb;
    logic        s_awready = 0, s_wready = 0, s_bvalid = 0, s_arready = 0, s_rvalid = 0, s_rlast = 0;
    logic [1:0]  s_bresp = 0, s_rresp = 0;
    logic [31:0] s_rdata = 0;

    always #2.5 clk = ~clk;

    memfill_verify dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
        .fail(fail), .fail_addr(fail_addr),
        .m_awvalid(m_awvalid), .m_awready(s_awready), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
        .m_awsize(m_awsize), .m_awburst(m_awburst), .m_awprot(m_awprot),
        .m_wvalid(m_wvalid), .m_wready(s_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_wlast(m_wlast), .m_bvalid(s_bvalid), .m_bready(m_bready), .m_bresp(s_bresp),
        .m_arvalid(m_arvalid), .m_arready(s_arready), .m_araddr(m_araddr), .m_arlen(m_arlen),
        .m_arsize(m_arsize), .m_arburst(m_arburst), .m_arprot(m_arprot),
        .m_rvalid(s_rvalid), .m_rready(m_rready), .m_rdata(s_rdata), .m_rresp(s_rresp),
        .m_rlast(s_rlast)
    );

    // expected-value functions
    function automatic logic [31:0] exp_word_addr(input int i);
        return BASE + 32'(i) * 32'd4;
    endfunction
    function automatic logic [31:0] exp_burst_addr(input int k);
        return BASE + 32'(k) * 32'd64;
    endfunction

    // slave model configuration and bookkeeping
    int stall_pct = 30;
    int c0 = -1, c1 = -1, berr = -1, rerr = -1;
    logic [31:0] mem [0:TOTAL-1];
    logic [31:0] aq_w [0:15];
    logic [31:0] aq_r [0:15];
    int aw_n, w_n, w_beat, w_burst, pend_b, b_n, ar_n, r_n, r_beat, r_burst;
    int aw_bad = 0, w_bad = 0, ar_bad = 0, stab_bad = 0, rdy_bad = 0;
    logic p_aw_wait = 0, p_w_wait = 0, p_ar_wait = 0;
    logic [31:0] p_awaddr = 0, p_wdata = 0, p_araddr = 0;
    logic p_wlast = 0;

    function automatic logic roll();
        return ($urandom_range(99) >= 32'(stall_pct));
    endfunction

    always @(posedge clk) begin
        int idx;
        logic bv, rv;
        if (rst || model_clr) begin
            aw_n = 0; w_n = 0; w_beat = 0; w_burst = 0; pend_b = 0; b_n = 0;
            ar_n = 0; r_n = 0; r_beat = 0; r_burst = 0;
            p_aw_wait = 0; p_w_wait = 0; p_ar_wait = 0;
            if (model_clr) for (int i = 0; i < TOTAL; i++) mem[i] = 32'hFFFF_FFFF;
            s_awready <= 0; s_wready <= 0; s_bvalid <= 0; s_arready <= 0; s_rvalid <= 0;
        end else begin
            // R6 monitor: stalled payload must hold
            if (p_aw_wait && (!m_awvalid || m_awaddr != p_awaddr)) stab_bad++;
            if (p_w_wait && (!m_wvalid || m_wdata != p_wdata || m_wlast != p_wlast)) stab_bad++;
            if (p_ar_wait && (!m_arvalid || m_araddr != p_araddr)) stab_bad++;
            p_aw_wait = m_awvalid && !s_awready; p_awaddr = m_awaddr;
            p_w_wait  = m_wvalid && !s_wready;   p_wdata = m_wdata; p_wlast = m_wlast;
            p_ar_wait = m_arvalid && !s_arready; p_araddr = m_araddr;
            // R10 monitor
            if (m_rready && b_n < NB) rdy_bad++;
            if (m_bready && b_n == NB) rdy_bad++;
            // write address
            if (m_awvalid && s_awready) begin
                if (m_awaddr != exp_burst_addr(aw_n) || m_awlen != 8'd15 || m_awsize != 3'd2 ||
                    m_awburst != 2'd1 || m_awprot != 3'd0) aw_bad++;
                aq_w[aw_n % 16] = m_awaddr;
                aw_n++;
            end
            s_awready <= roll();
            // write data
            if (m_wvalid && s_wready) begin
                idx = int'((aq_w[w_burst % 16] - BASE) >> 2) + w_beat;
                if (idx >= 0 && idx < TOTAL) mem[idx] = m_wdata;
                if (m_wdata != 32'(w_n) || m_wlast != (w_beat == BL - 1) || m_wstrb != 4'hF) w_bad++;
                w_n++;
                if (w_beat == BL - 1) begin w_beat = 0; w_burst++; pend_b++; end
                else w_beat++;
            end
            s_wready <= roll() && (w_burst < aw_n);
            // read address (checked before this edge's write response counts)
            if (m_arvalid && s_arready) begin
                if (b_n < NB) ar_bad++;
                if (m_araddr != exp_burst_addr(ar_n) || m_arlen != 8'd15 || m_arsize != 3'd2 ||
                    m_arburst != 2'd1 || m_arprot != 3'd0) ar_bad++;
                aq_r[ar_n % 16] = m_araddr;
                ar_n++;
            end
            s_arready <= roll();
            // write response
            if (s_bvalid && m_bready) b_n++;
            bv = s_bvalid && !m_bready;
            if (!bv && pend_b > 0 && roll()) begin
                s_bvalid <= 1; s_bresp <= (b_n == berr) ? 2'b10 : 2'b00; pend_b--;
            end else s_bvalid <= bv;
            // read data
            if (s_rvalid && m_rready) begin
                r_n++;
                if (r_beat == BL - 1) begin r_beat = 0; r_burst++; end else r_beat++;
            end
            rv = s_rvalid && !m_rready;
            if (!rv && r_burst < ar_n && roll()) begin
                idx = int'((aq_r[r_burst % 16] - BASE) >> 2) + r_beat;
                s_rdata <= ((idx >= 0 && idx < TOTAL) ? mem[idx] : 32'h0BAD_0BAD) ^
                           ((idx == c0 || idx == c1) ? 32'h0000_0100 : 32'h0);
                s_rresp <= (idx == rerr) ? 2'b10 : 2'b00;
                s_rlast <= (r_beat == BL - 1);
                s_rvalid <= 1;
            end else s_rvalid <= rv;
        end
    end

    int n_checks = 0, n_fail = 0;

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic clr_model();
        @(negedge clk) model_clr = 1;
        @(negedge clk) model_clr = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        check(done, "R9", "watchdog: done never rose", 32'(done), 32'd1);
    endtask

    task automatic run(input int k0, input int k1, input int be, input int re, input int sp);
        c0 = k0; c1 = k1; berr = be; rerr = re; stall_pct = sp;
        clr_model();
        pulse_start();
        check(busy && !done, "R2", "busy after start", {30'd0, busy, done}, 32'd2);
        wait_done();
    endtask

    initial begin
        int a, b, lo, bad;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(!m_awvalid && !m_wvalid && !m_arvalid, "R1", "valids low after reset",
              {29'd0, m_awvalid, m_wvalid, m_arvalid}, 32'd0);
        check(!busy && !done && !pass && !fail && fail_addr == 0, "R1", "status idle after reset",
              {28'd0, busy, done, pass, fail}, 32'd0);

        // clean run with random stalls
        run(-1, -1, -1, -1, 30);
        check(pass && !fail, "R9", "clean run passes", {30'd0, pass, fail}, 32'd2);
        check(aw_n == NB && aw_bad == 0, "R3", "write bursts count/fields", 32'(aw_n), 32'(NB));
        check(w_n == TOTAL && w_bad == 0, "R4", "write beats data/last", 32'(w_bad), 32'd0);
        bad = 0;
        for (int i = 0; i < TOTAL; i++) if (mem[i] != 32'(i)) bad++;
        check(bad == 0, "R4", "memory holds index pattern", 32'(bad), 32'd0);
        check(ar_n == NB && ar_bad == 0, "R5", "read bursts order/fields", 32'(ar_bad), 32'd0);
        check(r_n == TOTAL, "R9", "all read beats taken", 32'(r_n), 32'(TOTAL));
        repeat (5) @(negedge clk);
        check(done && pass, "R9", "done holds", {30'd0, done, pass}, 32'd3);

        // two corrupted words: first one reported
        run(37, 90, -1, -1, 50);
        check(fail && !pass, "R7", "mismatch sets fail", {30'd0, fail, pass}, 32'd2);
        check(fail_addr == exp_word_addr(37), "R7", "first mismatch address", fail_addr, exp_word_addr(37));

        // restart clears the previous failure; full-throughput slave
        c0 = -1; c1 = -1; stall_pct = 0;
        clr_model();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        check(!done && !fail && busy, "R2", "start clears done/fail", {29'd0, done, fail, busy}, 32'd1);
        wait_done();
        check(pass && fail_addr == 0, "R2", "rerun passes after failure", fail_addr, 32'd0);

        // start while busy is ignored
        stall_pct = 40;
        clr_model();
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start();
        check(busy, "R2", "still busy after extra start", 32'(busy), 32'd1);
        wait_done();
        check(aw_n == NB && w_n == TOTAL && r_n == TOTAL && pass, "R2", "extra start had no effect",
              32'(aw_n), 32'(NB));

        // write response error on burst 3
        run(-1, -1, 3, -1, 25);
        check(fail && fail_addr == exp_burst_addr(3), "R8", "bad write response address",
              fail_addr, exp_burst_addr(3));
        check(r_n == TOTAL, "R8", "read phase still ran", 32'(r_n), 32'(TOTAL));

        // read response error at 150 precedes corruption at 155
        run(155, -1, -1, 150, 25);
        check(fail && fail_addr == exp_word_addr(150), "R8", "bad read response address",
              fail_addr, exp_word_addr(150));

        // random corruption pairs
        for (int t = 0; t < 3; t++) begin
            a = int'($urandom_range(TOTAL - 1));
            b = int'($urandom_range(TOTAL - 1));
            lo = (a < b) ? a : b;
            run(a, b, -1, -1, int'($urandom_range(60)));
            check(fail && fail_addr == exp_word_addr(lo), "R7", "random first mismatch",
                  fail_addr, exp_word_addr(lo));
        end

        check(stab_bad == 0, "R6", "payload held while stalled", 32'(stab_bad), 32'd0);
        check(rdy_bad == 0, "R10", "response readies confined to phase", 32'(rdy_bad), 32'd0);
        check(ar_bad == 0, "R5", "no read before all write responses", 32'(ar_bad), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule